// File: doc/BRIEF.md
# Serial Register Front End for a Twelve-Channel Low-Side Driver

This block is the serial control port of a twelve-channel low-side driver. A bus master lowers the active-low chip select, clocks in a sixteen-bit frame and raises the chip select again. The frame holds a four-bit address and then twelve data bits, most significant bit first. When the chip select rises, the data goes to the channel enable register or to one of the configuration registers, according to the address. During the same frame the block shifts back four live fault flags, then a twelve-bit readback word chosen by the address just received.

Several devices can share the data-in and data-out lines, each with its own chip select. The serial output is therefore presented as a data bit plus an output enable for the pad, so the pad can float whenever the device is not selected. All pins are sampled by a fast system clock, which makes every event a registered edge inside one clock domain. The master owns the serial clock, so the link has no back-pressure and no valid/ready pair. Control, status and the channel outputs are plain pins.

Top module: `spi_drv_regif`

## Requirements
- R1: A frame is 16 bits: address bits 3..0, then data bits 11..0, both most significant bit first. Each data-in bit is taken on a falling edge of the serial clock.
- R2: so_oe_o is 0 while the chip select is high and 1 while it is low. Each change follows the pin within four system clocks.
- R3: The first four output bits are the fault flags in the order flt_i[3] (supply), flt_i[2] (overtemperature), flt_i[1] (attention/stall), flt_i[0] (overcurrent). Bit 0 is present before the first rising serial clock edge. Every rising edge after the first one moves the output to the next bit.
- R4: Output bits 4..15 are readback bits 11..0. Address 0 returns the channel enables. Addresses 1 to 3 return configuration register 1 to 3. Any other address returns zero.
- R5: Registers are written only after the chip select rises. Nothing changes while the chip select stays low.
- R6: Address 0 loads ch_en_o, and data bit i drives channel i.
- R7: Addresses 1 to 3 load configuration register k, which appears on cfg_o[(k-1)*12 +: 12].
- R8: A frame that does not hold exactly 16 falling serial clock edges when the chip select rises updates no register.
- R9: Addresses 4 to 15 write nothing.
- R10: Reset clears every register, so all channels are off and so_oe_o is 0.
- R11: The fault flags are captured when the chip select falls. Later changes on flt_i do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ceb_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, idle low |
| si_i | input | 1 | Serial data in |
| flt_i | input | 4 | Fault flags: supply, overtemperature, attention, overcurrent |
| so_o | output | 1 | Serial data out, valid while so_oe_o is 1 |
| so_oe_o | output | 1 | Pad drive enable for so_o |
| ch_en_o | output | 12 | Channel enables, bit i for channel i |
| cfg_o | output | 36 | Configuration registers 1 to 3, register 1 in the low field |

## Verification
The assertions assume that the chip select is high through reset and for the first clocks after it. They also assume that the serial clock is low whenever the chip select moves, and that every pin level lasts well beyond the synchronizer depth. The flag checks further assume that flt_i is steady in the clock before the chip select falls. The bench changes the serial clock and the chip select only every eight system clocks. It changes data-in together with the rising serial edge, sets the flags two clocks before a frame starts, and raises the serial clock only after the chip select has been low for a full phase.

// File: rtl/spi_drv_pkg.sv
package spi_drv_pkg;

  // Events derived from the oversampled serial pins, one clock wide each.
  typedef struct packed {
    logic ceb_fall;
    logic ceb_rise;
    logic sclk_rise;
    logic sclk_fall;
    logic si;
  } spi_evt_t;

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync
  import spi_drv_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ceb_i,
  input  logic     sclk_i,
  input  logic     si_i,
  output spi_evt_t evt_o
);

  logic [STAGES-1:0] ceb_q, sclk_q, si_q;
  logic              ceb_d, sclk_d;
  logic              ceb_s, sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ceb_q  <= '1;
      sclk_q <= '0;
      si_q   <= '0;
      ceb_d  <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      ceb_q  <= {ceb_q[STAGES-2:0], ceb_i};
      sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
      si_q   <= {si_q[STAGES-2:0], si_i};
      ceb_d  <= ceb_s;
      sclk_d <= sclk_s;
    end
  end

  assign ceb_s  = ceb_q[STAGES-1];
  assign sclk_s = sclk_q[STAGES-1];

  always_comb begin
    evt_o.ceb_fall  = ceb_d & ~ceb_s;
    evt_o.ceb_rise  = ~ceb_d & ceb_s;
    evt_o.sclk_rise = ~ceb_s & ~sclk_d & sclk_s;
    evt_o.sclk_fall = ~ceb_s & sclk_d & ~sclk_s;
    evt_o.si        = si_q[STAGES-1];
  end

endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_drv_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 12,
  parameter int STAT_W = 4,
  localparam int FW    = ADDR_W + DATA_W,
  localparam int CNT_W = $clog2(FW + 2),
  localparam int IDX_W = $clog2(FW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  spi_evt_t          evt_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [CNT_W-1:0]  frame_len_o,
  output logic              so_o,
  output logic              so_oe_o
);

  localparam logic [CNT_W-1:0] LEN_SAT  = CNT_W'(FW + 1);
  localparam logic [CNT_W-1:0] IDX_END  = CNT_W'(FW);
  localparam logic [CNT_W-1:0] ADDR_LST = CNT_W'(ADDR_W - 1);
  localparam logic [IDX_W-1:0] TX_TOP   = IDX_W'(FW - 1);

  logic [FW-1:0]     rx_q;
  logic [CNT_W-1:0]  rx_cnt_q, tx_idx_q;
  logic [STAT_W-1:0] stat_q;
  logic [DATA_W-1:0] rd_q;
  logic              first_q, ld_pend_q, oe_q;
  logic [FW-1:0]     tx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q      <= '0;
      rx_cnt_q  <= '0;
      tx_idx_q  <= '0;
      stat_q    <= '0;
      rd_q      <= '0;
      first_q   <= 1'b0;
      ld_pend_q <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      if (ld_pend_q) begin
        rd_q      <= rdata_i;
        ld_pend_q <= 1'b0;
      end
      if (evt_i.sclk_rise) begin
        if (first_q) begin
          if (tx_idx_q != IDX_END) tx_idx_q <= tx_idx_q + 1'b1;
        end else begin
          first_q <= 1'b1;
        end
      end
      if (evt_i.sclk_fall) begin
        rx_q <= {rx_q[FW-2:0], evt_i.si};
        if (rx_cnt_q != LEN_SAT) rx_cnt_q <= rx_cnt_q + 1'b1;
        if (rx_cnt_q == ADDR_LST) ld_pend_q <= 1'b1;
      end
      if (evt_i.ceb_rise) oe_q <= 1'b0;
      if (evt_i.ceb_fall) begin
        oe_q      <= 1'b1;
        stat_q    <= stat_i;
        rd_q      <= '0;
        rx_cnt_q  <= '0;
        tx_idx_q  <= '0;
        first_q   <= 1'b0;
        ld_pend_q <= 1'b0;
      end
    end
  end

  assign tx_word     = {stat_q, rd_q};
  assign so_o        = (tx_idx_q < IDX_END) ? tx_word[TX_TOP - tx_idx_q[IDX_W-1:0]] : 1'b0;
  assign so_oe_o     = oe_q;
  assign rd_addr_o   = rx_q[ADDR_W-1:0];
  assign wr_addr_o   = rx_q[FW-1 -: ADDR_W];
  assign wr_data_o   = rx_q[DATA_W-1:0];
  assign frame_len_o = rx_cnt_q;

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 12,
  parameter int NUM_CFG = 3,
  localparam int FW     = ADDR_W + DATA_W,
  localparam int CNT_W  = $clog2(FW + 2),
  localparam int SEL_W  = $clog2(NUM_CFG + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit_i,
  input  logic [CNT_W-1:0]          len_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  output logic [DATA_W-1:0]         ch_en_o,
  output logic [NUM_CFG*DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0]         rdata_o
);

  logic [NUM_CFG:0][DATA_W-1:0] regs_q;
  logic                         we;

  assign we = commit_i && (len_i == CNT_W'(FW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else begin
      for (int k = 0; k <= NUM_CFG; k++) begin
        if (we && wr_addr_i == ADDR_W'(k)) regs_q[k] <= wr_data_i;
      end
    end
  end

  assign rdata_o = (rd_addr_i <= ADDR_W'(NUM_CFG)) ? regs_q[rd_addr_i[SEL_W-1:0]] : '0;
  assign ch_en_o = regs_q[0];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    assign cfg_o[g*DATA_W +: DATA_W] = regs_q[g+1];
  end

endmodule

// File: rtl/spi_drv_regif.sv
module spi_drv_regif
  import spi_drv_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 12,
  parameter int STAT_W      = 4,
  parameter int NUM_CFG     = 3,
  parameter int SYNC_STAGES = 2,
  localparam int FW         = ADDR_W + DATA_W,
  localparam int CNT_W      = $clog2(FW + 2)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ceb_i,
  input  logic                      sclk_i,
  input  logic                      si_i,
  input  logic [STAT_W-1:0]         flt_i,
  output logic                      so_o,
  output logic                      so_oe_o,
  output logic [DATA_W-1:0]         ch_en_o,
  output logic [NUM_CFG*DATA_W-1:0] cfg_o
);

  spi_evt_t          evt;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] wr_data, rdata;
  logic [CNT_W-1:0]  frame_len;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .ceb_i(ceb_i), .sclk_i(sclk_i), .si_i(si_i), .evt_o(evt)
  );

  spi_frame_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) shft_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .stat_i(flt_i), .rdata_i(rdata),
    .rd_addr_o(rd_addr), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .frame_len_o(frame_len), .so_o(so_o), .so_oe_o(so_oe_o)
  );

  spi_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CFG(NUM_CFG)) regs_i (
    .clk(clk), .rst_n(rst_n), .commit_i(evt.ceb_rise), .len_i(frame_len),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .ch_en_o(ch_en_o), .cfg_o(cfg_o), .rdata_o(rdata)
  );

endmodule

// File: rtl/spi_drv_regif_chk.sv
module spi_drv_regif_chk #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 12,
  parameter int STAT_W  = 4,
  parameter int NUM_CFG = 3,
  localparam int FW     = ADDR_W + DATA_W,
  localparam int CNT_W  = $clog2(FW + 2)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ceb_i,
  input logic [STAT_W-1:0]         flt_i,
  input logic                      so_o,
  input logic                      so_oe_o,
  input logic [DATA_W-1:0]         ch_en_o,
  input logic [NUM_CFG*DATA_W-1:0] cfg_o,
  input logic [CNT_W-1:0]          frame_len
);

  // R2: pad floats once the select has been high for four samples
  p_float_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ceb_i && $past(ceb_i) && $past(ceb_i, 2) && $past(ceb_i, 3)) |-> !so_oe_o);

  // R2: pad drives once the select has been low for four samples
  p_drive_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ceb_i && !$past(ceb_i) && !$past(ceb_i, 2) && !$past(ceb_i, 3)) |-> so_oe_o);

  // R3 / R11: first bit on the pad is the supply flag captured at the select fall
  p_first_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe_o) |-> (so_o == $past(flt_i[STAT_W-1])));

  // R5: registers hold while the select stays low
  p_hold_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ceb_i && !$past(ceb_i) && !$past(ceb_i, 2) && !$past(ceb_i, 3))
      |-> ($stable(ch_en_o) && $stable(cfg_o)));

  // R8: a register change needs a complete frame
  p_full_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ch_en_o, cfg_o}) |-> ($past(frame_len) == CNT_W'(FW)));

endmodule

bind spi_drv_regif spi_drv_regif_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W), .NUM_CFG(NUM_CFG)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ceb_i(ceb_i), .flt_i(flt_i), .so_o(so_o),
  .so_oe_o(so_oe_o), .ch_en_o(ch_en_o), .cfg_o(cfg_o), .frame_len(frame_len)
);

// File: tb/spi_drv_regif_tb_top.sv
`timescale 1ns/1ps
module spi_drv_regif_tb_top;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ceb = 1'b1, sclk = 1'b0, si = 1'b0;
  logic [3:0]  flt = 4'h0;
  logic        so, so_oe;
  logic [11:0] ch_en;
  logic [35:0] cfg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [11:0] ch_m;
  logic [11:0] cfg_m [3];

  always #2 clk = ~clk;

  spi_drv_regif dut_i (
    .clk(clk), .rst_n(rst_n), .ceb_i(ceb), .sclk_i(sclk), .si_i(si), .flt_i(flt),
    .so_o(so), .so_oe_o(so_oe), .ch_en_o(ch_en), .cfg_o(cfg)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  function automatic logic [11:0] exp_rd(input logic [3:0] a);
    if (a == 4'd0) return ch_m;
    if (a <= 4'd3) return cfg_m[a - 4'd1];
    return 12'h000;
  endfunction

  task automatic run_frame(input logic [3:0] adr, input logic [11:0] dat, input int nbits,
                           input logic [3:0] f, input bit flip,
                           output logic [15:0] got, output logic [1:0] oe_seen);
    logic [15:0] word;
    word = {adr, dat};
    got  = '0;
    flt  = f;
    tick(2);
    ceb = 1'b0;
    tick(HALF);
    oe_seen[1] = so_oe;
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1;
      si   = (i < 16) ? word[15 - i] : 1'b0;
      if (flip && i == 0) flt = ~f;
      tick(HALF);
      if (i < 16) got[15 - i] = so;
      sclk = 1'b0;
      tick(HALF);
    end
    ceb = 1'b1;
    tick(HALF);
    oe_seen[0] = so_oe;
  endtask

  task automatic model_commit(input logic [3:0] adr, input logic [11:0] dat, input int nbits);
    if (nbits == 16) begin
      if (adr == 4'd0) ch_m = dat;
      else if (adr <= 4'd3) cfg_m[adr - 4'd1] = dat;
    end
  endtask

  task automatic check_regs(input string req);
    chk({req, " ch_en"}, {24'h0, ch_en}, {24'h0, ch_m});
    chk({req, " cfg"}, cfg, {cfg_m[2], cfg_m[1], cfg_m[0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    logic [1:0]  oe_seen;
    logic [11:0] dat;
    ch_m = '0;
    cfg_m[0] = '0; cfg_m[1] = '0; cfg_m[2] = '0;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R10: reset state
    chk("R10 ch_en", {24'h0, ch_en}, 36'h0);
    chk("R10 cfg", cfg, 36'h0);
    chk("R10 so_oe", {35'h0, so_oe}, 36'h0);

    // R1 R2 R3 R4 R6 R7 R9: two passes over every address, second pass reads the first
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < 16; a++) begin
        dat = 12'((a * 12'h1B7 + 12'h035) ^ (pass * 12'hFFF));
        run_frame(4'(a), dat, 16, 4'(a) ^ 4'h9, 1'b0, got, oe_seen);
        chk("R3 status", {32'h0, got[15:12]}, {32'h0, 4'(a) ^ 4'h9});
        chk("R4 readback", {24'h0, got[11:0]}, {24'h0, exp_rd(4'(a))});
        chk("R2 oe low/high", {34'h0, oe_seen}, 36'h2);
        model_commit(4'(a), dat, 16);
        if (a == 0) check_regs("R6");
        else if (a <= 3) check_regs("R7");
        else check_regs("R9");
      end
    end

    // R1 R6: walking one across the channel enables, bit order
    for (int b = 0; b < 12; b++) begin
      run_frame(4'd0, 12'(1 << b), 16, 4'h0, 1'b0, got, oe_seen);
      model_commit(4'd0, 12'(1 << b), 16);
      check_regs("R1");
    end

    // R8: short and long frames are discarded
    for (int k = 0; k < 4; k++) begin
      int nb;
      nb = (k == 0) ? 15 : (k == 1) ? 17 : (k == 2) ? 4 : 0;
      run_frame(4'(k), 12'hA5A, nb, 4'h0, 1'b0, got, oe_seen);
      check_regs("R8");
    end

    // R5: registers unchanged while select still low mid-frame
    flt = 4'h0;
    tick(2);
    ceb = 1'b0;
    tick(HALF);
    for (int i = 0; i < 16; i++) begin
      sclk = 1'b1;
      si = (i >= 4) ? 1'b1 : 1'b0;
      tick(HALF);
      sclk = 1'b0;
      tick(HALF);
    end
    tick(3 * HALF);
    check_regs("R5 held");
    ceb = 1'b1;
    tick(HALF);
    model_commit(4'd0, 12'hFFF, 16);
    check_regs("R5 commit");

    // R11: flags changed after the select fall do not reach this frame
    run_frame(4'd2, 12'h3C3, 16, 4'b1010, 1'b1, got, oe_seen);
    chk("R11 status", {32'h0, got[15:12]}, 36'hA);
    chk("R4 cfg2 read", {24'h0, got[11:0]}, {24'h0, cfg_m[1]});
    model_commit(4'd2, 12'h3C3, 16);
    check_regs("R7 after flip");

    // R4: read back a freshly written configuration register
    run_frame(4'd2, 12'h000, 16, 4'h5, 1'b0, got, oe_seen);
    chk("R4 readback cfg2", {24'h0, got[11:0]}, 36'h3C3);
    chk("R3 status 5", {32'h0, got[15:12]}, 36'h5);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule